// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Half-Bit Stop Lengths

This block turns parallel bytes into asynchronous serial frames on a single line. The line rests high. Each frame has three parts, sent in this order:

- one low start bit;
- eight data bits, least significant bit first;
- a high stop period of one, one and a half, or two bit times.

Timing comes from an enable pulse (`tick`) that the surrounding logic supplies at sixteen times the bit rate. One counter times every bit segment. Each segment ends after a fixed number of ticks from the previous segment boundary, so timing errors do not build up from one bit to the next.

Bytes arrive over a valid/ready handshake. The block raises `in_ready` during the stop period, so the next byte and its stop setting can be taken before the current frame ends. A waiting byte starts its start bit on the same tick that ends the current stop period. A continuous stream therefore has exactly the configured stop length between frames.

The half-bit setting adds about 5% to the frame length, from 10 to 10.5 bit times. That small extra gap lets a receiver whose bit rate is slightly fast get back into step during long streams.

Top module: `uart_frac_stop_tx`

## Requirements
- R1: After reset, `tx_out` is 1, `busy` is 0 and `in_ready` is 1. Whenever `busy` is 0, `tx_out` is 1.
- R2: A frame is one start bit at 0, then the 8 bits of the accepted byte starting with bit 0, then the stop period at 1.
- R3: Let j count the tick pulses after the acceptance clock edge. The start bit holds while j is below 16. Data bit k holds while j is in [16+16k, 32+16k). The stop period begins at j = 144.
- R4: `in_stop` = 0 gives a stop period of 16 ticks.
- R5: `in_stop` = 1 gives a stop period of 24 ticks.
- R6: `in_stop` = 2 or 3 gives a stop period of 32 ticks.
- R7: `in_ready` is 1 only while the block is idle, or during a stop period in which no byte has yet been taken. It is 0 during start and data bits.
- R8: When a byte is waiting, its start bit begins on the tick that ends the previous stop period, with no extra idle ticks.
- R9: `in_stop` is sampled on the cycle its byte is accepted. Later changes to `in_stop` do not affect that frame.
- R10: `busy` rises on the cycle after a byte is accepted from idle. It stays 1 until the tick that ends the last stop period with no byte waiting, and then falls to 0.
- R11: While `busy` is 1, `tx_out` changes only on cycles where `tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle enable at 16 times the bit rate |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Byte can be taken this cycle |
| in_data | input | 8 | Byte to send |
| in_stop | input | 2 | Stop length: 0 is 1 bit, 1 is 1.5 bits, 2 and 3 are 2 bits |
| tx_out | output | 1 | Serial line, idles high |
| busy | output | 1 | A frame is in progress |

## Verification
The bench records the line and `busy` on every tick and compares them with a tick-by-tick model built from the bytes it sent.

- A single isolated byte covers the path from idle to sending and back to idle.
- Streams of 0x00, 0xFF, 0x55, 0xAA, 0x01 and 0x80 under each stop setting separate bit-order errors, stuck bits and off-by-one shift errors from stop-length errors.
- A stream whose stop length changes from frame to frame, while `in_stop` is flipped right after every acceptance, shows whether the setting is latched at acceptance.
- A sweep of all 256 byte values with back-to-back frames shows any gap or overlap at frame boundaries.

// File: rtl/uart_fstx_pkg.sv
package uart_fstx_pkg;

   typedef enum logic [1:0] {
      TX_IDLE  = 2'd0,
      TX_START = 2'd1,
      TX_DATA  = 2'd2,
      TX_STOP  = 2'd3
   } tx_phase_e;

   typedef enum logic [1:0] {
      STOP_ONE      = 2'd0,
      STOP_ONE_HALF = 2'd1,
      STOP_TWO      = 2'd2,
      STOP_TWO_ALT  = 2'd3
   } stop_cfg_e;

endpackage

// File: rtl/uart_fstx_seg_timer.sv
// Counts ticks within the current bit segment and flags its last tick.
module uart_fstx_seg_timer #(
   parameter int CW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic          tick,
   input  logic [CW-1:0] seg_len,
   output logic          seg_done
);
   logic [CW-1:0] cnt;
   logic          at_end;

   assign at_end   = (cnt == seg_len - 1'b1);
   assign seg_done = tick && !restart && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (restart) begin
         cnt <= '0;
      end else if (tick) begin
         if (at_end) cnt <= '0;
         else        cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/uart_fstx_shifter.sv
// Holds the byte being sent; bit 0 drives the line during data bits.
module uart_fstx_shifter #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] load_val,
   input  logic          shift,
   output logic          lsb
);
   logic [DW-1:0] sh;
   logic [DW-1:0] sh_nxt;

   for (genvar i = 0; i < DW; i++) begin : g_sh
      if (i == DW - 1) begin : g_top
         assign sh_nxt[i] = 1'b1;
      end else begin : g_mid
         assign sh_nxt[i] = sh[i+1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sh <= '1;
      else if (load)  sh <= load_val;
      else if (shift) sh <= sh_nxt;
   end

   assign lsb = sh[0];
endmodule

// File: rtl/uart_fstx_ctrl.sv
// Frame sequencer: phases, stop-length selection and the one-byte holding slot.
module uart_fstx_ctrl
   import uart_fstx_pkg::*;
#(
   parameter int DW = 8,
   parameter int OS = 16,
   parameter int CW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          seg_done,
   input  logic          in_valid,
   input  logic [DW-1:0] in_data,
   input  logic [1:0]    in_stop,
   output logic          in_ready,
   output logic          timer_restart,
   output logic [CW-1:0] seg_len,
   output logic          sh_load,
   output logic [DW-1:0] sh_val,
   output logic          sh_shift,
   input  logic          sh_lsb,
   output logic          tx_out,
   output logic          busy
);
   localparam int BW = (DW > 1) ? $clog2(DW) : 1;
   localparam logic [CW-1:0] LEN_BIT  = CW'(OS);
   localparam logic [CW-1:0] LEN_HALF = CW'(OS + OS / 2);
   localparam logic [CW-1:0] LEN_TWO  = CW'(2 * OS);
   localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

   tx_phase_e     phase;
   logic [1:0]    cur_stop;
   logic [BW-1:0] bit_idx;
   logic          hold_vld;
   logic [DW-1:0] hold_data;
   logic [1:0]    hold_stop;
   logic          accept;
   logic          stop_end;
   logic          from_hold;
   logic          from_input;

   assign in_ready      = (phase == TX_IDLE) || ((phase == TX_STOP) && !hold_vld);
   assign accept        = in_valid && in_ready;
   assign stop_end      = (phase == TX_STOP) && seg_done;
   assign timer_restart = accept && (phase == TX_IDLE);
   assign from_hold     = stop_end && hold_vld;
   assign from_input    = timer_restart || (stop_end && !hold_vld && accept);
   assign sh_load       = from_hold || from_input;
   assign sh_val        = from_hold ? hold_data : in_data;
   assign sh_shift      = (phase == TX_DATA) && seg_done && (bit_idx != LAST_BIT);

   always_comb begin
      seg_len = LEN_BIT;
      if (phase == TX_STOP) begin
         case (stop_cfg_e'(cur_stop))
            STOP_ONE:      seg_len = LEN_BIT;
            STOP_ONE_HALF: seg_len = LEN_HALF;
            default:       seg_len = LEN_TWO;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= TX_IDLE;
         cur_stop  <= '0;
         bit_idx   <= '0;
         hold_vld  <= 1'b0;
         hold_data <= '0;
         hold_stop <= '0;
      end else begin
         case (phase)
            TX_IDLE: begin
               if (accept) begin
                  phase    <= TX_START;
                  cur_stop <= in_stop;
               end
            end
            TX_START: begin
               if (seg_done) begin
                  phase   <= TX_DATA;
                  bit_idx <= '0;
               end
            end
            TX_DATA: begin
               if (seg_done) begin
                  if (bit_idx == LAST_BIT) phase <= TX_STOP;
                  else                     bit_idx <= bit_idx + 1'b1;
               end
            end
            default: begin
               if (seg_done) begin
                  if (hold_vld) begin
                     phase    <= TX_START;
                     cur_stop <= hold_stop;
                     hold_vld <= 1'b0;
                  end else if (accept) begin
                     phase    <= TX_START;
                     cur_stop <= in_stop;
                  end else begin
                     phase    <= TX_IDLE;
                  end
               end else if (accept) begin
                  hold_vld  <= 1'b1;
                  hold_data <= in_data;
                  hold_stop <= in_stop;
               end
            end
         endcase
      end
   end

   always_comb begin
      case (phase)
         TX_START: tx_out = 1'b0;
         TX_DATA:  tx_out = sh_lsb;
         default:  tx_out = 1'b1;
      endcase
   end

   assign busy = (phase != TX_IDLE);
endmodule

// File: rtl/uart_frac_stop_tx.sv
module uart_frac_stop_tx #(
   parameter int DATA_BITS  = 8,
   parameter int OVERSAMPLE = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic [DATA_BITS-1:0] in_data,
   input  logic [1:0]           in_stop,
   output logic                 tx_out,
   output logic                 busy
);
   localparam int CW = $clog2(2 * OVERSAMPLE + 1);

   if (DATA_BITS < 1) begin : g_bad_width
      $error("DATA_BITS must be at least 1");
   end
   if (OVERSAMPLE < 4 || (OVERSAMPLE % 2) != 0) begin : g_bad_os
      $error("OVERSAMPLE must be even and at least 4 for half-bit stops");
   end

   logic          seg_done;
   logic          timer_restart;
   logic [CW-1:0] seg_len;
   logic          sh_load;
   logic [DATA_BITS-1:0] sh_val;
   logic          sh_shift;
   logic          sh_lsb;

   uart_fstx_seg_timer #(.CW(CW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (timer_restart),
      .tick     (tick),
      .seg_len  (seg_len),
      .seg_done (seg_done)
   );

   uart_fstx_shifter #(.DW(DATA_BITS)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (sh_load),
      .load_val (sh_val),
      .shift    (sh_shift),
      .lsb      (sh_lsb)
   );

   uart_fstx_ctrl #(.DW(DATA_BITS), .OS(OVERSAMPLE), .CW(CW)) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .seg_done      (seg_done),
      .in_valid      (in_valid),
      .in_data       (in_data),
      .in_stop       (in_stop),
      .in_ready      (in_ready),
      .timer_restart (timer_restart),
      .seg_len       (seg_len),
      .sh_load       (sh_load),
      .sh_val        (sh_val),
      .sh_shift      (sh_shift),
      .sh_lsb        (sh_lsb),
      .tx_out        (tx_out),
      .busy          (busy)
   );
endmodule

// File: rtl/uart_fstx_chk.sv
module uart_fstx_chk (
   input logic clk,
   input logic rst_n,
   input logic tick,
   input logic in_valid,
   input logic in_ready,
   input logic tx_out,
   input logic busy
);
   // R1
   idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> tx_out);

   // R7
   ready_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> (!busy || tx_out));

   // R10
   accept_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !busy) |=> busy);

   // R2
   start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !tx_out);

   // R11
   tick_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tick) |=> ($stable(tx_out) && busy));

   // R10
   busy_ends_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(tick) && tx_out));
endmodule

bind uart_frac_stop_tx uart_fstx_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick     (tick),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .tx_out   (tx_out),
   .busy     (busy)
);

// File: tb/uart_frac_stop_tx_bench.sv
`timescale 1ns/1ps
module uart_frac_stop_tx_bench;
   localparam int LOGN = 49152;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       tick_q = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [7:0] in_data = 8'h00;
   logic [1:0] in_stop = 2'd0;
   logic       tx_out;
   logic       busy;

   int compared = 0;
   int mismatched = 0;
   int wr = 0;
   int cyc = 0;
   bit done = 1'b0;
   logic txlog [LOGN];
   logic bzlog [LOGN];
   logic rdlog [LOGN];
   logic [7:0] sb [256];
   logic [1:0] ss [256];

   uart_frac_stop_tx u_uart_frac_stop_tx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .in_valid(in_valid),
      .in_ready(in_ready), .in_data(in_data), .in_stop(in_stop),
      .tx_out(tx_out), .busy(busy)
   );

   always #2 clk = ~clk;

   always @(negedge clk) tick <= ~tick;
   always @(posedge clk) tick_q = tick;
   always @(negedge clk) begin
      if (tick_q && wr < LOGN) begin
         txlog[wr] = tx_out;
         bzlog[wr] = busy;
         rdlog[wr] = in_ready;
         wr = wr + 1;
      end
   end

   always @(posedge clk) begin
      cyc = cyc + 1;
      if (cyc > 190000 && !done) begin
         done = 1'b1;
         mismatched = mismatched + 1;
         $display("FAIL watchdog expired actual=%0d expected<=190000 cycles", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      compared = compared + 1;
      if (!ok) begin
         mismatched = mismatched + 1;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int stop_len(input logic [1:0] s);
      case (s)
         2'd0:    return 16;
         2'd1:    return 24;
         default: return 32;
      endcase
   endfunction

   task automatic send(input logic [7:0] b, input logic [1:0] s);
      in_data  = b;
      in_stop  = s;
      in_valid = 1'b1;
      while (!in_ready) begin
         @(negedge clk); #1;
      end
      @(negedge clk); #1;
      in_valid = 1'b0;
      in_stop  = ~s;   // R9: config flips right after acceptance
   endtask

   task automatic run_stream(input int n, input string name);
      int f;
      int total;
      @(negedge clk); #1;
      while (tick || busy) begin
         @(negedge clk); #1;
      end
      wr = 0;
      for (int i = 0; i < n; i++) send(sb[i], ss[i]);
      while (busy) begin
         @(negedge clk); #1;
      end
      repeat (100) @(negedge clk);
      #1;
      total = 0;
      for (int i = 0; i < n; i++) total += 144 + stop_len(ss[i]);
      chk(wr >= total + 40, {name, " log length R10"}, wr, total + 40);
      if (wr < total + 40) return;
      f = 0;
      for (int i = 0; i < n; i++) begin
         int bad_body = 0;
         int bad_stop = 0;
         int bad_rdy  = 0;
         int sl = stop_len(ss[i]);
         for (int q = 0; q < 144; q++) begin
            int p = f + q;
            logic e = (q < 16) ? 1'b0 : sb[i][(q - 16) / 16];
            if (p >= 1) begin
               if (txlog[p-1] !== e) bad_body++;
               if (rdlog[p-1] !== 1'b0) bad_rdy++;
            end
         end
         for (int q = 144; q < 144 + sl; q++)
            if (txlog[f+q-1] !== 1'b1) bad_stop++;
         // R2 R3
         chk(bad_body == 0, {name, " frame body R2 R3"}, bad_body, 0);
         // R7
         chk(bad_rdy == 0, {name, " ready low in body R7"}, bad_rdy, 0);
         case (ss[i])
            2'd0:    chk(bad_stop == 0, {name, " stop 16 ticks R4 R9"}, bad_stop, 0);
            2'd1:    chk(bad_stop == 0, {name, " stop 24 ticks R5 R9"}, bad_stop, 0);
            default: chk(bad_stop == 0, {name, " stop 32 ticks R6 R9"}, bad_stop, 0);
         endcase
         if (i > 0)
            // R8
            chk(txlog[f-1] === 1'b0 && txlog[f-2] === 1'b1, {name, " no gap R8"},
                int'(txlog[f-1]), 0);
         f += 144 + sl;
      end
      // R7
      chk(rdlog[f - stop_len(ss[n-1]) + 144 - 144] === 1'b1, {name, " ready in last stop R7"},
          int'(rdlog[f - stop_len(ss[n-1])]), 1);
      begin
         int bad_bz = 0;
         int bad_tail = 0;
         for (int p = 1; p < total + 40; p++)
            if (bzlog[p-1] !== (p < total)) bad_bz++;
         for (int p = total; p < total + 40; p++)
            if (txlog[p-1] !== 1'b1) bad_tail++;
         // R10
         chk(bad_bz == 0, {name, " busy window R10"}, bad_bz, 0);
         // R1 R11
         chk(bad_tail == 0, {name, " idle high after R1 R11"}, bad_tail, 0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      // R1
      chk(tx_out === 1'b1, "reset line R1", int'(tx_out), 1);
      chk(busy === 1'b0, "reset busy R1", int'(busy), 0);
      chk(in_ready === 1'b1, "reset ready R1", int'(in_ready), 1);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      sb[0] = 8'hA5; ss[0] = 2'd1;
      run_stream(1, "single");

      for (int cfg = 0; cfg < 4; cfg++) begin
         sb[0] = 8'h00; sb[1] = 8'hFF; sb[2] = 8'h55;
         sb[3] = 8'hAA; sb[4] = 8'h01; sb[5] = 8'h80;
         for (int i = 0; i < 6; i++) ss[i] = 2'(cfg);
         run_stream(6, $sformatf("stream cfg%0d", cfg));
      end

      sb[0] = 8'h3C; sb[1] = 8'hC3; sb[2] = 8'h0F;
      sb[3] = 8'hF0; sb[4] = 8'h69; sb[5] = 8'h96;
      ss[0] = 2'd0; ss[1] = 2'd1; ss[2] = 2'd2;
      ss[3] = 2'd1; ss[4] = 2'd0; ss[5] = 2'd3;
      run_stream(6, "mixed");

      for (int i = 0; i < 256; i++) begin
         sb[i] = 8'(i);
         ss[i] = 2'(i % 4);
      end
      run_stream(256, "sweep");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule